// File: doc/BRIEF.md
# Sixteen-bit multicycle register-machine core

This block is a small processor core that runs a compact 16-bit instruction set over eight 16-bit general registers. Each instruction takes three phases: fetch, latch and execute. In the fetch phase the core reads the word at the program counter. In the latch phase it captures that word as the instruction and advances the counter. In the execute phase it decodes the instruction, forms any address it needs and carries it out. A memory load adds one more phase, in which the returned word is written back.

The core talks to a synchronous, single-port, word-addressed memory whose read data arrives one clock after the address. It also drives a simple I/O port with an 8-bit port number. A run flag gates all activity. After reset the core sits idle until a start pulse sets the flag. It clears the flag again when it meets opcode zero or an opcode it does not implement.

The core implements this subset of the instruction set:
- register and immediate moves;
- three kinds of shift;
- load and store with a base-plus-displacement address;
- port input and output;
- an absolute jump;
- a relative jump taken only when a register is non-negative.

Top module: `rcore16`

## Requirements
- R1: After reset `run_o` is 0, and the core drives no memory write, I/O read or I/O write. While `start_i` stays low the core stays in this state and executes nothing.
- R2: A one-cycle `start_i` pulse while halted sets `run_o` and starts fetching at the current program counter, which is 0 after reset. Every instruction other than a load takes exactly 3 cycles. The execute phase of the k-th instruction (k counted from 1) falls in cycle 3k-1 after the clock edge that samples `start_i`.
- R3: The encoding uses bits [15:11] as the opcode, [10:8] as ra, [7:5] as rb, [4:0] as the short constant c1 and [7:0] as the long constant c2. Opcode 6 copies R[rb] into R[ra]. Opcode 7 writes c2, sign-extended from bit 7, into R[ra].
- R4: Opcode 12 writes R[rb] shifted left by N, with zero fill, into R[ra]. Opcode 13 writes R[rb] shifted right logically by N, with zero fill. Opcode 15 writes R[rb] shifted right arithmetically by N, copying bit 15. In all three, N is c1[3:0], giving a range of 0 to 15.
- R5: Load (opcode 29) and store (opcode 28) use the address R[rb] plus c1 sign-extended from bit 4. Load writes the memory word into R[ra], and store writes R[ra] to memory. When the rb field is 0 the base is zero whatever R0 holds, which gives direct addresses from -16 to +15.
- R6: Opcode 24 writes the I/O read data of port c2 into R[ra]. Opcode 25 presents R[ra] on port c2 with `io_we_o` high for one cycle. At most one of `mem_we_o`, `io_we_o` and `io_re_o` is high in any cycle.
- R7: Opcode 20 sets the program counter to R[ra] plus c2 sign-extended.
- R8: Opcode 16 sets the program counter to the incremented program counter plus c2 sign-extended, but only when bit 15 of R[ra] is clear. Otherwise execution continues with the next word. The jump reaches from 128 words back to 127 words forward.
- R9: Opcode 0 or any opcode not listed above clears `run_o`, and no further instruction executes. A later `start_i` pulse resumes at the word after the halting one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse to set the run flag while halted |
| run_o | output | 1 | Run flag |
| mem_addr_o | output | 16 | Memory word address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the address |
| io_addr_o | output | 8 | I/O port number |
| io_re_o | output | 1 | I/O read strobe |
| io_we_o | output | 1 | I/O write strobe |
| io_wdata_o | output | 16 | I/O write data |
| io_rdata_i | input | 16 | I/O read data, sampled in the same cycle as the strobe |

## Verification
An I/O write appears during the execute phase of its instruction, which is cycle 3k-1 after the edge that samples the start pulse. The bench logs each strobe at the falling edge together with its cycle number, and checks one write against that exact cycle. Register results are not visible at the ports, so every program writes them out through port output instructions. Stored words are read back from the bench memory only after `run_o` has fallen. A load returns its data one cycle after the address, so a stored or output result never needs to be sampled before the instruction that follows it.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
    parameter int XLEN  = 16;
    parameter int NREG  = 8;
    parameter int RIDX  = $clog2(NREG);
    parameter int OPW   = 5;
    parameter int PORTW = 8;
    parameter int C1W   = 5;
    parameter int SHW   = 4;

    localparam logic [OPW-1:0] OP_HALT = 5'd0;
    localparam logic [OPW-1:0] OP_MOV  = 5'd6;
    localparam logic [OPW-1:0] OP_MOVI = 5'd7;
    localparam logic [OPW-1:0] OP_SHL  = 5'd12;
    localparam logic [OPW-1:0] OP_SHR  = 5'd13;
    localparam logic [OPW-1:0] OP_ASR  = 5'd15;
    localparam logic [OPW-1:0] OP_JPL  = 5'd16;
    localparam logic [OPW-1:0] OP_JMP  = 5'd20;
    localparam logic [OPW-1:0] OP_IN   = 5'd24;
    localparam logic [OPW-1:0] OP_OUT  = 5'd25;
    localparam logic [OPW-1:0] OP_ST   = 5'd28;
    localparam logic [OPW-1:0] OP_LD   = 5'd29;

    typedef enum logic [2:0] {ST_HALT, ST_FETCH, ST_LATCH, ST_EXEC, ST_LOAD} phase_e;
    typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARI} shkind_e;

    typedef struct packed {
        logic [OPW-1:0]   op;
        logic [RIDX-1:0]  ra;
        logic [RIDX-1:0]  rb;
        logic [C1W-1:0]   c1;
        logic [PORTW-1:0] c2;
    } fields_t;

    typedef struct packed {
        phase_e          st;
        logic            run;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
    } core_t;
endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
    import rcore_pkg::*;
(
    input  logic [XLEN-1:0] ir_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] ra_val_i,
    input  logic [XLEN-1:0] rb_val_i,
    output fields_t         f_o,
    output logic [XLEN-1:0] imm_o,
    output logic [XLEN-1:0] disp_addr_o,
    output logic [XLEN-1:0] rel_addr_o,
    output logic [XLEN-1:0] abs_addr_o
);
    logic [XLEN-1:0] short_d;
    logic [XLEN-1:0] base_d;

    always_comb begin
        // fixed field positions of the encoding
        f_o.op  = ir_i[15:11];
        f_o.ra  = ir_i[10:8];
        f_o.rb  = ir_i[7:5];
        f_o.c1  = ir_i[4:0];
        f_o.c2  = ir_i[7:0];
        imm_o   = {{(XLEN-PORTW){ir_i[7]}}, ir_i[7:0]};
        short_d = {{(XLEN-C1W){ir_i[4]}}, ir_i[4:0]};
        base_d  = (ir_i[7:5] == '0) ? '0 : rb_val_i;
        disp_addr_o = base_d + short_d;
        rel_addr_o  = pc_i + imm_o;
        abs_addr_o  = ra_val_i + imm_o;
    end
endmodule

// File: rtl/rcore_shift.sv
module rcore_shift
    import rcore_pkg::*;
(
    input  logic [XLEN-1:0] val_i,
    input  logic [SHW-1:0]  amt_i,
    input  shkind_e         kind_i,
    output logic [XLEN-1:0] res_o
);
    always_comb begin
        unique case (kind_i)
            SH_LEFT: res_o = val_i << amt_i;
            SH_RLOG: res_o = val_i >> amt_i;
            default: res_o = $unsigned($signed(val_i) >>> amt_i);
        endcase
    end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile
    import rcore_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [RIDX-1:0] waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [RIDX-1:0] raddr_a_i,
    input  logic [RIDX-1:0] raddr_b_i,
    output logic [XLEN-1:0] rdata_a_o,
    output logic [XLEN-1:0] rdata_b_o
);
    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we_i) regs_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata_a_o = regs_q[raddr_a_i];
    assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/rcore16.sv
module rcore16
    import rcore_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             run_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic             mem_re_o,
    output logic             mem_we_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    input  logic [XLEN-1:0]  mem_rdata_i,
    output logic [PORTW-1:0] io_addr_o,
    output logic             io_re_o,
    output logic             io_we_o,
    output logic [XLEN-1:0]  io_wdata_o,
    input  logic [XLEN-1:0]  io_rdata_i
);
    core_t           c_q, c_d;
    fields_t         f;
    logic [XLEN-1:0] ra_val, rb_val, imm, disp_addr, rel_addr, abs_addr, sh_res;
    logic            rf_we;
    logic [XLEN-1:0] rf_wdata;
    shkind_e         sh_kind;

    rcore_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .we_i(rf_we), .waddr_i(f.ra), .wdata_i(rf_wdata),
        .raddr_a_i(f.ra), .raddr_b_i(f.rb), .rdata_a_o(ra_val), .rdata_b_o(rb_val)
    );

    rcore_decode u_dec (
        .ir_i(c_q.ir), .pc_i(c_q.pc), .ra_val_i(ra_val), .rb_val_i(rb_val),
        .f_o(f), .imm_o(imm), .disp_addr_o(disp_addr), .rel_addr_o(rel_addr),
        .abs_addr_o(abs_addr)
    );

    always_comb begin
        if (f.op == OP_SHL)      sh_kind = SH_LEFT;
        else if (f.op == OP_SHR) sh_kind = SH_RLOG;
        else                     sh_kind = SH_RARI;
    end

    rcore_shift u_sh (
        .val_i(rb_val), .amt_i(f.c1[SHW-1:0]), .kind_i(sh_kind), .res_o(sh_res)
    );

    always_comb begin
        c_d         = c_q;
        rf_we       = 1'b0;
        rf_wdata    = '0;
        mem_addr_o  = c_q.pc;
        mem_re_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = ra_val;
        io_addr_o   = f.c2;
        io_re_o     = 1'b0;
        io_we_o     = 1'b0;
        io_wdata_o  = ra_val;
        unique case (c_q.st)
            ST_HALT: begin
                if (start_i) begin
                    c_d.run = 1'b1;
                    c_d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_re_o = 1'b1;
                c_d.st   = ST_LATCH;
            end
            ST_LATCH: begin
                c_d.ir = mem_rdata_i;
                c_d.pc = c_q.pc + 1'b1;
                c_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                c_d.st = ST_FETCH;
                unique case (f.op)
                    OP_MOV:  begin rf_we = 1'b1; rf_wdata = rb_val; end
                    OP_MOVI: begin rf_we = 1'b1; rf_wdata = imm; end
                    OP_SHL, OP_SHR, OP_ASR: begin rf_we = 1'b1; rf_wdata = sh_res; end
                    OP_IN:   begin io_re_o = 1'b1; rf_we = 1'b1; rf_wdata = io_rdata_i; end
                    OP_OUT:  io_we_o = 1'b1;
                    OP_ST:   begin mem_addr_o = disp_addr; mem_we_o = 1'b1; end
                    OP_LD:   begin mem_addr_o = disp_addr; mem_re_o = 1'b1; c_d.st = ST_LOAD; end
                    OP_JMP:  c_d.pc = abs_addr;
                    OP_JPL:  if (!ra_val[XLEN-1]) c_d.pc = rel_addr;
                    default: begin c_d.run = 1'b0; c_d.st = ST_HALT; end
                endcase
            end
            ST_LOAD: begin
                rf_we    = 1'b1;
                rf_wdata = mem_rdata_i;
                c_d.st   = ST_FETCH;
            end
            default: begin
                c_d.run = 1'b0;
                c_d.st  = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st  <= ST_HALT;
            c_q.run <= 1'b0;
            c_q.pc  <= '0;
            c_q.ir  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign run_o = c_q.run;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (!mem_we_o && !io_we_o && !io_re_o));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, io_we_o, io_re_o}));

    // R2
    fetch_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |-> run_o);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_LATCH) |=> (c_q.pc == $past(c_q.pc) + 16'd1));

    // R9
    halt_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_EXEC && f.op == OP_HALT) |=> !run_o);

    // R8
    jpl_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_EXEC && f.op == OP_JPL && ra_val[XLEN-1]) |=> $stable(c_q.pc));
endmodule

// File: tb/tb_rcore16.sv
module tb_rcore16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        run;
    logic [15:0] mem_addr, mem_wdata, io_wdata, io_rdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_re, mem_we, io_re, io_we;
    logic [7:0]  io_addr;

    logic [15:0] mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          start_cyc = 0;
    int          nlog = 0;
    logic [7:0]  log_port [16];
    logic [15:0] log_val  [16];
    int          log_cyc  [16];

    always #2 clk = ~clk;

    rcore16 dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .run_o(run),
        .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .io_addr_o(io_addr), .io_re_o(io_re), .io_we_o(io_we),
        .io_wdata_o(io_wdata), .io_rdata_i(io_rdata)
    );

    assign io_rdata = {8'hA5, io_addr};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(negedge clk) begin
        if (io_we && nlog < 16) begin
            log_port[nlog] = io_addr;
            log_val[nlog]  = io_wdata;
            log_cyc[nlog]  = cyc;
            nlog = nlog + 1;
        end
    end

    function automatic logic [15:0] e_rr(input logic [4:0] op, input logic [2:0] ra,
                                         input logic [2:0] rb, input logic [4:0] c1);
        return {op, ra, rb, c1};
    endfunction

    function automatic logic [15:0] e_c2(input logic [4:0] op, input logic [2:0] ra,
                                         input logic [7:0] c2);
        return {op, ra, c2};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        nlog = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_cyc = cyc;
    endtask

    task automatic wait_halt(input string req);
        int n = 0;
        while (run && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({req, " halt reached"}, {31'd0, run}, 32'd0);
    endtask

    task automatic t_reset();
        clear_mem();
        do_reset();
        // R1: idle after reset, no strobes, no activity without start
        check("R1 run after reset", {31'd0, run}, 32'd0);
        check("R1 strobes after reset", {29'd0, mem_we, io_we, io_re}, 32'd0);
        repeat (10) @(negedge clk);
        check("R1 still idle without start", {30'd0, run, mem_re}, 32'd0);
    endtask

    task automatic t_moves();
        clear_mem();
        mem[0] = e_c2(5'd7, 3'd1, 8'hFD);
        mem[1] = e_rr(5'd6, 3'd2, 3'd1, 5'd0);
        mem[2] = e_c2(5'd25, 3'd2, 8'h05);
        mem[3] = e_c2(5'd7, 3'd3, 8'h7F);
        mem[4] = e_c2(5'd25, 3'd3, 8'h06);
        do_reset();
        pulse_start();
        check("R2 run set by start", {31'd0, run}, 32'd1);
        wait_halt("R9");
        check("R3 output count", nlog, 2);
        check("R3 mov of negative movi", {8'd0, log_port[0], log_val[0]}, {8'd0, 8'h05, 16'hFFFD});
        check("R3 movi positive", {8'd0, log_port[1], log_val[1]}, {8'd0, 8'h06, 16'h007F});
        // R2: third instruction executes in cycle 3*3-1 after the start edge
        check("R2 out timing", log_cyc[0] - start_cyc, 8);
    endtask

    task automatic t_shifts();
        clear_mem();
        mem[0]  = e_c2(5'd7, 3'd1, 8'h81);
        mem[1]  = e_rr(5'd12, 3'd2, 3'd1, 5'd4);
        mem[2]  = e_c2(5'd25, 3'd2, 8'h01);
        mem[3]  = e_rr(5'd13, 3'd2, 3'd1, 5'd4);
        mem[4]  = e_c2(5'd25, 3'd2, 8'h02);
        mem[5]  = e_rr(5'd15, 3'd2, 3'd1, 5'd4);
        mem[6]  = e_c2(5'd25, 3'd2, 8'h03);
        mem[7]  = e_rr(5'd12, 3'd2, 3'd1, 5'd0);
        mem[8]  = e_c2(5'd25, 3'd2, 8'h04);
        mem[9]  = e_rr(5'd15, 3'd2, 3'd1, 5'd15);
        mem[10] = e_c2(5'd25, 3'd2, 8'h05);
        mem[11] = e_rr(5'd13, 3'd2, 3'd1, 5'h1F);
        mem[12] = e_c2(5'd25, 3'd2, 8'h06);
        do_reset();
        pulse_start();
        wait_halt("R4");
        check("R4 shift count", nlog, 6);
        check("R4 shl 4", log_val[0], 16'hF810);
        check("R4 shr 4", log_val[1], 16'h0FF8);
        check("R4 asr 4", log_val[2], 16'hFFF8);
        check("R4 shl 0", log_val[3], 16'hFF81);
        check("R4 asr 15", log_val[4], 16'hFFFF);
        check("R4 shr 15 (c1 bit4 ignored)", log_val[5], 16'h0001);
    endtask

    task automatic t_loadstore();
        clear_mem();
        mem[0] = e_c2(5'd7, 3'd0, 8'h55);
        mem[1] = e_c2(5'd7, 3'd1, 8'h40);
        mem[2] = e_rr(5'd29, 3'd2, 3'd1, 5'h1E);
        mem[3] = e_rr(5'd28, 3'd2, 3'd1, 5'd5);
        mem[4] = e_rr(5'd29, 3'd3, 3'd0, 5'h10);
        mem[5] = e_rr(5'd28, 3'd3, 3'd0, 5'h0F);
        mem[6] = e_c2(5'd25, 3'd3, 8'h07);
        mem[8'h3E] = 16'h1234;
        mem[8'hF0] = 16'hBEEF;
        do_reset();
        pulse_start();
        wait_halt("R5");
        check("R5 store base+5 of loaded base-2", mem[8'h45], 16'h1234);
        check("R5 direct store +15", mem[8'h0F], 16'hBEEF);
        check("R5 direct load -16", {8'd0, log_port[0], log_val[0]}, {8'd0, 8'h07, 16'hBEEF});
    endtask

    task automatic t_io();
        clear_mem();
        mem[0] = e_c2(5'd24, 3'd1, 8'h33);
        mem[1] = e_c2(5'd25, 3'd1, 8'h01);
        do_reset();
        pulse_start();
        wait_halt("R6");
        check("R6 io count", nlog, 1);
        check("R6 in then out", {8'd0, log_port[0], log_val[0]}, {8'd0, 8'h01, 16'hA533});
    endtask

    task automatic t_jumps();
        clear_mem();
        mem[0]     = e_c2(5'd7,  3'd1, 8'h05);
        mem[1]     = e_c2(5'd16, 3'd1, 8'h02);
        mem[2]     = e_c2(5'd25, 3'd1, 8'hE0);
        mem[4]     = e_c2(5'd7,  3'd2, 8'hFF);
        mem[5]     = e_c2(5'd16, 3'd2, 8'h03);
        mem[6]     = e_c2(5'd25, 3'd2, 8'h10);
        mem[7]     = e_c2(5'd7,  3'd3, 8'h20);
        mem[8]     = e_c2(5'd20, 3'd3, 8'hFE);
        mem[9]     = e_c2(5'd25, 3'd2, 8'hE1);
        mem[8'h1E] = e_c2(5'd25, 3'd3, 8'h11);
        mem[8'h1F] = e_c2(5'd16, 3'd1, 8'h80);
        mem[8'hA0] = e_c2(5'd25, 3'd1, 8'h12);
        do_reset();
        pulse_start();
        wait_halt("R7");
        check("R8 jump count", nlog, 3);
        check("R8 taken skip then not taken", {8'd0, log_port[0], log_val[0]}, {8'd0, 8'h10, 16'hFFFF});
        check("R7 absolute jump R3-2", {8'd0, log_port[1], log_val[1]}, {8'd0, 8'h11, 16'h0020});
        check("R8 back 128 from incremented pc", {8'd0, log_port[2], log_val[2]}, {8'd0, 8'h12, 16'h0005});
    endtask

    task automatic t_halt_restart();
        clear_mem();
        mem[0] = e_c2(5'd7, 3'd1, 8'h09);
        mem[1] = e_c2(5'd3, 3'd1, 8'h01);
        mem[2] = e_c2(5'd25, 3'd1, 8'h01);
        do_reset();
        pulse_start();
        wait_halt("R9");
        repeat (5) @(negedge clk);
        check("R9 unknown op stops outputs", nlog, 0);
        check("R9 stays halted", {31'd0, run}, 32'd0);
        pulse_start();
        wait_halt("R9");
        check("R9 resume after halting word", {8'd0, log_port[0], log_val[0]}, {8'd0, 8'h01, 16'h0009});
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_moves();
        t_shifts();
        t_loadstore();
        t_io();
        t_jumps();
        t_halt_restart();
        finish_run();
    end
endmodule